// File: doc/BRIEF.md
# Single-Channel 1-Wire Bus Master Core

This core drives one open-drain 1-Wire line on behalf of a host that issues single-cycle command strobes. It can generate a bus reset and record whether a slave answered or the line was shorted. It can also transfer whole bytes as eight bit slots, sent least significant bit first, where a read byte uses read slots and samples the slave's reply. All line timing is measured in microsecond ticks taken from the system clock. A configuration bit chooses standard or overdrive timing for every command that follows.

The host sees an 8-bit status byte and the last byte read. A busy flag marks the time the line is in use. A separate read strobe captures the current line level into the status byte without starting any bus activity. A device-reset flag shows that the core has come out of reset and has not yet been configured. The line input passes through a two-stage synchronizer before any logic uses it.

Top module: `ow_master`

## Requirements
- R1: After rst_n is released the status byte reads 0x10 (only the device-reset flag set), read_data is 0x00 and the line is not driven.
- R2: Status bit 0 (busy) reads 1 from the cycle after an accepted bus reset, write-byte or read-byte strobe until that command completes. A bus reset keeps busy high for 960 µs plus at most 4 clocks. While busy is 0 the line is never driven low.
- R3: A bus reset drives the line low for 480 µs (standard) or 48 µs (overdrive). Status bit 2 (short) is set if the line is low 8 µs (standard) or 1 µs (overdrive) after release. Status bit 1 (presence) is set if the line is low 70 µs or 8 µs after release. These two bits change only when a bus reset completes or on a device reset.
- R4: If the short bit is 1, the presence bit is 0. A later bus reset that sees the line high at both sample points clears both bits.
- R5: A write-byte command sends host_data LSB first. A 1 bit drives the line low for 6 µs (standard) or 1 µs (overdrive). A 0 bit drives it low for 60 µs or 8 µs. Each slot lasts 65 µs or 10 µs.
- R6: A read-byte command runs eight read slots with a 6 µs (standard) or 1 µs (overdrive) low pulse. It samples the line 15 µs or 2 µs into each slot, fills the byte LSB first, and places it on read_data when the command completes.
- R7: Status bit 3 (line level) takes the synchronized line value on each status_rd strobe and holds otherwise. A status read never drives the line.
- R8: Status bit 4 (device reset) is set by rst_n or by an accepted cmd_dev_reset. It is cleared by an accepted cmd_write_cfg. A device reset also clears the short, presence and line-level bits.
- R9: cmd_write_cfg loads cfg_overdrive as the speed bit, and every later command uses overdrive timing when it is 1 and standard timing when it is 0. A device reset returns the speed to standard.
- R10: Any command strobe that arrives while busy is 1 is ignored: it causes no line activity, does not change the speed and does not change the status.
- R11: Status bits 7 to 5 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_bus_reset | input | 1 | Strobe: run a bus reset with presence and short detection |
| cmd_write_byte | input | 1 | Strobe: send host_data as eight write slots |
| cmd_read_byte | input | 1 | Strobe: receive a byte with eight read slots |
| cmd_write_cfg | input | 1 | Strobe: load the speed bit and clear the device-reset flag |
| cmd_dev_reset | input | 1 | Strobe: return the core to its after-reset state |
| host_data | input | 8 | Byte to send with cmd_write_byte |
| cfg_overdrive | input | 1 | Speed bit loaded by cmd_write_cfg (1 = overdrive) |
| status_rd | input | 1 | Strobe: host reads status; refreshes the line-level bit |
| status | output | 8 | Status byte {3'b000, dev_reset, level, short, presence, busy} |
| read_data | output | 8 | Byte from the last completed read-byte command |
| ow_drive_low | output | 1 | 1 pulls the open-drain line low; 0 releases it |
| ow_line_in | input | 1 | Line level as seen at the pad |

## Verification
The embedded assertions check the cycle-level rules on every clock. The line is released whenever busy is low, and short excludes presence. The short and presence bits move only while a command is in progress. A configuration write clears the device-reset flag, the speed bit holds while busy, and each engine completion lasts one cycle.

Other behaviour shows only in the bench's scenarios, run against a slave model that can answer with presence, return chosen data bits, or hold the line low. These include the exact pulse lengths per bit value and speed, LSB-first ordering, the data read back, and how long busy stays high. They also include the short-versus-presence outcomes, line-level refresh only on a status read, and the rejection of strobes issued during a command.

// File: rtl/ow_pkg.sv
// Shared types and line timing for the 1-Wire master.
// Assumes: all times are whole microseconds counted from the start of a
// command; one counter width covers the longest sequence (reset, 960 us).
package ow_pkg;

    localparam int BYTE_W     = 8;
    localparam int BIT_IDX_W  = $clog2(BYTE_W);
    localparam int MAX_US     = 960;
    localparam int CNT_W      = $clog2(MAX_US + 1);

    // Status byte bit positions (host software decodes these).
    localparam int ST_BUSY  = 0;
    localparam int ST_PRES  = 1;
    localparam int ST_SHORT = 2;
    localparam int ST_LEVEL = 3;
    localparam int ST_DEVRST = 4;

    // Times in microseconds measured from the start of a reset or a slot.
    typedef struct packed {
        logic [CNT_W-1:0] rst_low;     // line held low during reset
        logic [CNT_W-1:0] short_at;    // short sample instant
        logic [CNT_W-1:0] pres_at;     // presence sample instant
        logic [CNT_W-1:0] rst_total;   // end of reset sequence
        logic [CNT_W-1:0] low_one;     // low time for write-1 / read slot
        logic [CNT_W-1:0] low_zero;    // low time for write-0 slot
        logic [CNT_W-1:0] samp_at;     // read sample instant
        logic [CNT_W-1:0] slot_total;  // end of one bit slot
    } ow_timing_t;

    localparam ow_timing_t TIM_STD = '{
        rst_low:   CNT_W'(480), short_at: CNT_W'(488), pres_at: CNT_W'(550),
        rst_total: CNT_W'(960), low_one:  CNT_W'(6),   low_zero: CNT_W'(60),
        samp_at:   CNT_W'(15),  slot_total: CNT_W'(65)
    };

    localparam ow_timing_t TIM_OD = '{
        rst_low:   CNT_W'(48),  short_at: CNT_W'(49),  pres_at: CNT_W'(56),
        rst_total: CNT_W'(96),  low_one:  CNT_W'(1),   low_zero: CNT_W'(8),
        samp_at:   CNT_W'(2),   slot_total: CNT_W'(10)
    };

    typedef enum logic [1:0] {ENG_IDLE, ENG_RESET, ENG_SLOT} eng_state_t;
    typedef enum logic [1:0] {MST_IDLE, MST_RESET, MST_BYTE} mst_state_t;

endpackage

// File: rtl/ow_sync.sv
// Multi-stage synchronizer for the asynchronous line input.
// Assumes: the idle bus is high, so every stage resets to 1.
module ow_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    // Shift the pad value through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], async_in};
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/ow_timebase.sv
// Microsecond tick generator. The divider restarts on clr so that a command
// begins exactly on a microsecond boundary.
// Assumes: CLKS_PER_US >= 1 system clocks make one microsecond.
module ow_timebase #(
    parameter int CLKS_PER_US = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int DIV_W = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLKS_PER_US - 1);

    logic [DIV_W-1:0] div_q;

    // Count clocks within the current microsecond.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)        div_q <= '0;
        else if (div_q == DIV_LAST) div_q <= '0;
        else                        div_q <= div_q + 1'b1;
    end

    assign tick = (div_q == DIV_LAST);

    generate
        if (CLKS_PER_US > 1) begin : g_tick_chk
            AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
                (tick && !clr) |=> !tick); // R5
        end
    endgenerate
endmodule

// File: rtl/ow_slot_engine.sv
// Times one bus reset or one bit slot. Reports the presence/short samples of
// a reset, or the sampled bit of a slot, with a one-cycle done pulse.
// Assumes: a start arrives only while idle; timing is chosen at start.
module ow_slot_engine
    import ow_pkg::*;
#(
    parameter int CLKS_PER_US = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_rst,
    input  logic start_slot,
    input  logic bit_val,
    input  logic od_sel,
    input  logic line_hi,
    output logic drive_low,
    output logic done,
    output logic samp_bit,
    output logic pres_seen,
    output logic short_seen
);
    eng_state_t       state;
    ow_timing_t       tm;
    logic [CNT_W-1:0] us_cnt;
    logic [CNT_W-1:0] us_next;
    logic             bit_q;
    logic             tick;
    logic             start_any;

    assign start_any = (state == ENG_IDLE) && (start_rst || start_slot);
    assign us_next   = us_cnt + 1'b1;

    ow_timebase #(.CLKS_PER_US(CLKS_PER_US)) u_tb (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (start_any),
        .tick (tick)
    );

    // Sequence state, microsecond count and sample captures.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ENG_IDLE;
            tm         <= TIM_STD;
            us_cnt     <= '0;
            bit_q      <= 1'b1;
            done       <= 1'b0;
            samp_bit   <= 1'b0;
            pres_seen  <= 1'b0;
            short_seen <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ENG_IDLE: begin
                    us_cnt <= '0;
                    tm     <= od_sel ? TIM_OD : TIM_STD;
                    if (start_rst)       state <= ENG_RESET;
                    else if (start_slot) begin
                        state <= ENG_SLOT;
                        bit_q <= bit_val;
                    end
                end
                ENG_RESET: if (tick) begin
                    us_cnt <= us_next;
                    if (us_next == tm.short_at) short_seen <= !line_hi;
                    if (us_next == tm.pres_at)  pres_seen  <= !line_hi;
                    if (us_next == tm.rst_total) begin
                        done  <= 1'b1;
                        state <= ENG_IDLE;
                    end
                end
                ENG_SLOT: if (tick) begin
                    us_cnt <= us_next;
                    if (us_next == tm.samp_at) samp_bit <= line_hi;
                    if (us_next == tm.slot_total) begin
                        done  <= 1'b1;
                        state <= ENG_IDLE;
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    // Pull the line low during the leading part of a reset or slot.
    always_comb begin
        drive_low = 1'b0;
        if (state == ENG_RESET)     drive_low = (us_cnt < tm.rst_low);
        else if (state == ENG_SLOT) drive_low = (us_cnt < (bit_q ? tm.low_one : tm.low_zero));
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
    AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(done) |-> !drive_low); // R2
endmodule

// File: rtl/ow_master.sv
// Single-channel 1-Wire master: accepts host command strobes, sequences
// resets and byte transfers through the slot engine, and keeps the status
// byte, speed bit and last read byte.
// Assumes: strobes are one clock wide; strobes seen while busy are dropped.
module ow_master
    import ow_pkg::*;
#(
    parameter int CLKS_PER_US = 125,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_bus_reset,
    input  logic              cmd_write_byte,
    input  logic              cmd_read_byte,
    input  logic              cmd_write_cfg,
    input  logic              cmd_dev_reset,
    input  logic [BYTE_W-1:0] host_data,
    input  logic              cfg_overdrive,
    input  logic              status_rd,
    output logic [7:0]        status,
    output logic [BYTE_W-1:0] read_data,
    output logic              ow_drive_low,
    input  logic              ow_line_in
);
    mst_state_t           mode;
    logic                 busy;
    logic                 is_read;
    logic [BYTE_W-1:0]    shreg;
    logic [BIT_IDX_W-1:0] bit_cnt;
    logic                 go_rst;
    logic                 go_slot;
    logic                 speed_od;
    logic                 devrst_flag;
    logic                 level_q;
    logic                 short_q;
    logic                 pres_q;
    logic                 line_hi;
    logic                 eng_done;
    logic                 eng_samp;
    logic                 eng_pres;
    logic                 eng_short;
    logic [BYTE_W-1:0]    shifted;

    ow_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(ow_line_in),
        .sync_out(line_hi)
    );

    ow_slot_engine #(.CLKS_PER_US(CLKS_PER_US)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_rst (go_rst),
        .start_slot(go_slot),
        .bit_val   (shreg[0]),
        .od_sel    (speed_od),
        .line_hi   (line_hi),
        .drive_low (ow_drive_low),
        .done      (eng_done),
        .samp_bit  (eng_samp),
        .pres_seen (eng_pres),
        .short_seen(eng_short)
    );

    assign shifted = {eng_samp, shreg[BYTE_W-1:1]};

    // Command acceptance, byte sequencing and status register updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode        <= MST_IDLE;
            busy        <= 1'b0;
            is_read     <= 1'b0;
            shreg       <= '1;
            bit_cnt     <= '0;
            go_rst      <= 1'b0;
            go_slot     <= 1'b0;
            speed_od    <= 1'b0;
            devrst_flag <= 1'b1;
            level_q     <= 1'b0;
            short_q     <= 1'b0;
            pres_q      <= 1'b0;
            read_data   <= '0;
        end else begin
            go_rst  <= 1'b0;
            go_slot <= 1'b0;
            if (!busy) begin
                if (cmd_dev_reset) begin
                    devrst_flag <= 1'b1;
                    speed_od    <= 1'b0;
                    short_q     <= 1'b0;
                    pres_q      <= 1'b0;
                    level_q     <= 1'b0;
                end else if (cmd_write_cfg) begin
                    speed_od    <= cfg_overdrive;
                    devrst_flag <= 1'b0;
                end else if (cmd_bus_reset) begin
                    busy   <= 1'b1;
                    mode   <= MST_RESET;
                    go_rst <= 1'b1;
                end else if (cmd_write_byte || cmd_read_byte) begin
                    busy    <= 1'b1;
                    mode    <= MST_BYTE;
                    is_read <= !cmd_write_byte;
                    shreg   <= cmd_write_byte ? host_data : '1;
                    bit_cnt <= '0;
                    go_slot <= 1'b1;
                end
            end else if (eng_done) begin
                if (mode == MST_RESET) begin
                    short_q <= eng_short;
                    pres_q  <= eng_pres && !eng_short;
                    busy    <= 1'b0;
                    mode    <= MST_IDLE;
                end else begin
                    shreg   <= shifted;
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == BIT_IDX_W'(BYTE_W - 1)) begin
                        busy <= 1'b0;
                        mode <= MST_IDLE;
                        if (is_read) read_data <= shifted;
                    end else begin
                        go_slot <= 1'b1;
                    end
                end
            end
            if (status_rd) level_q <= line_hi;
        end
    end

    assign status = {3'b000, devrst_flag, level_q, short_q, pres_q, busy};

    AST_RELEASED_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !status[ST_BUSY] |-> !ow_drive_low); // R2
    AST_SHORT_MASKS_PRES: assert property (@(posedge clk) disable iff (!rst_n)
        status[ST_SHORT] |-> !status[ST_PRES]); // R4
    AST_FLAGS_ONLY_BY_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[ST_BUSY] && !cmd_dev_reset) |=> $stable(status[ST_SHORT:ST_PRES])); // R3
    AST_CFG_CLEARS_DEVRST: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[ST_BUSY] && cmd_write_cfg && !cmd_dev_reset) |=> !status[ST_DEVRST]); // R8
    AST_SPEED_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        status[ST_BUSY] |=> $stable(speed_od)); // R10
endmodule

// File: tb/tb_ow_master.sv
`timescale 1ns/1ps
module tb_ow_master;
    localparam int C = 4;                    // clocks per microsecond in this bench
    localparam int L1S = 6,  L0S = 60, L1O = 1, L0O = 8;
    // Vector: [9] read command, [8] overdrive, [7:0] byte
    localparam logic [9:0] VEC [0:5] = '{
        {1'b0, 1'b0, 8'hA5}, {1'b0, 1'b0, 8'h0F}, {1'b0, 1'b1, 8'h3C},
        {1'b1, 1'b0, 8'h96}, {1'b1, 1'b1, 8'h5A}, {1'b1, 1'b0, 8'hFF}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_bus_reset = 0, cmd_write_byte = 0, cmd_read_byte = 0;
    logic cmd_write_cfg = 0, cmd_dev_reset = 0, cfg_overdrive = 0, status_rd = 0;
    logic [7:0] host_data = 8'h00;
    logic [7:0] status, read_data;
    logic ow_drive_low, ow_line_in;

    // Slave model state
    logic slave_low = 1'b0;
    logic short_hold = 1'b0;
    logic pres_on = 1'b1;
    logic od_b = 1'b0;
    logic rd_mode = 1'b0;
    logic [7:0] rd_byte = 8'h00;
    logic [2:0] rd_idx = 3'd0;
    int hold = 0, since_rel = 0, run = 0, np = 0;
    logic pres_act = 1'b0, prev_drv = 1'b0;
    int pulses [16];

    int n_chk = 0, n_fail = 0, cycles = 0;

    always #4 clk = ~clk;

    assign ow_line_in = !(ow_drive_low || slave_low || short_hold);

    ow_master #(.CLKS_PER_US(C)) dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_bus_reset(cmd_bus_reset), .cmd_write_byte(cmd_write_byte),
        .cmd_read_byte(cmd_read_byte), .cmd_write_cfg(cmd_write_cfg),
        .cmd_dev_reset(cmd_dev_reset), .host_data(host_data),
        .cfg_overdrive(cfg_overdrive), .status_rd(status_rd),
        .status(status), .read_data(read_data),
        .ow_drive_low(ow_drive_low), .ow_line_in(ow_line_in)
    );

    // Pulse monitor and slave responder, evaluated away from the active edge.
    always @(negedge clk) begin
        if (hold > 0) hold = hold - 1;
        if (pres_act) since_rel = since_rel + 1;
        if (ow_drive_low) begin
            run = run + 1;
            if (!prev_drv && rd_mode) begin
                if (!rd_byte[rd_idx]) hold = (od_b ? 4 : 30) * C;
                rd_idx = rd_idx + 3'd1;
            end
        end else if (prev_drv) begin
            if (np < 16) pulses[np] = run;
            np = np + 1;
            if (pres_on && run >= (od_b ? 30 : 200) * C) begin
                pres_act  = 1'b1;
                since_rel = 0;
            end
            run = 0;
        end
        if (pres_act && since_rel > (od_b ? 12 : 120) * C) pres_act = 1'b0;
        slave_low = (hold > 0) ||
                    (pres_act && since_rel >= (od_b ? 3 : 15) * C);
        prev_drv = ow_drive_low;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<190000", cycles);
            finish_run();
        end
    end

    // 0 bus reset, 1 write byte, 2 read byte, 3 write cfg, 4 device reset, 5 status read
    task automatic strobe(input int which);
        @(negedge clk);
        case (which)
            0: cmd_bus_reset  = 1'b1;
            1: cmd_write_byte = 1'b1;
            2: cmd_read_byte  = 1'b1;
            3: cmd_write_cfg  = 1'b1;
            4: cmd_dev_reset  = 1'b1;
            default: status_rd = 1'b1;
        endcase
        @(negedge clk);
        {cmd_bus_reset, cmd_write_byte, cmd_read_byte, cmd_write_cfg, cmd_dev_reset, status_rd} = '0;
    endtask

    task automatic wait_idle(output int busy_cycles);
        busy_cycles = 0;
        while (status[0]) begin
            busy_cycles++;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic set_speed(input logic od);
        cfg_overdrive = od;
        od_b = od;
        strobe(3);
    endtask

    initial begin
        int bc;
        int exp_len;
        bit ok;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(status == 8'h10, "R1 status after reset", status, 8'h10);
        check(read_data == 8'h00, "R1 read_data after reset", read_data, 0);
        check(ow_drive_low == 1'b0, "R1 line released", ow_drive_low, 0);

        // R8 configuration write clears device-reset flag
        set_speed(1'b0);
        check(status[4] == 1'b0, "R8 cfg clears dev-reset", status[4], 0);

        // Standard reset with presence
        np = 0; pres_on = 1'b1;
        strobe(0);
        check(status[0] == 1'b1, "R2 busy after reset strobe", status[0], 1);
        wait_idle(bc);
        check(bc >= 960*C - 1 && bc <= 960*C + 4, "R2 reset busy length", bc, 960*C);
        check(np == 1 && pulses[0] == 480*C, "R3 std reset low time", pulses[0], 480*C);
        check(status[2:1] == 2'b01, "R3 presence set, short clear", status[2:1], 1);
        check(status[7:5] == 3'b000, "R11 upper bits zero", status[7:5], 0);

        // Vector table: byte transfers at both speeds (R5, R6, R9)
        for (int v = 0; v < 6; v++) begin
            set_speed(VEC[v][8]);
            np = 0;
            if (VEC[v][9]) begin
                rd_byte = VEC[v][7:0];
                rd_idx  = 3'd0;
                rd_mode = 1'b1;
                strobe(2);
            end else begin
                host_data = VEC[v][7:0];
                strobe(1);
            end
            wait_idle(bc);
            rd_mode = 1'b0;
            ok = (np == 8);
            for (int b = 0; b < 8; b++) begin
                if (VEC[v][9] || VEC[v][b])
                    exp_len = (VEC[v][8] ? L1O : L1S) * C;
                else
                    exp_len = (VEC[v][8] ? L0O : L0S) * C;
                if (pulses[b] != exp_len) ok = 1'b0;
            end
            if (VEC[v][9]) begin
                check(ok, "R6 read slot low pulses", np, 8);
                check(read_data == VEC[v][7:0], "R6 read byte LSB first", read_data, VEC[v][7:0]);
            end else begin
                check(ok, "R5 write pulses LSB first", np, 8);
            end
            check(status[0] == 1'b0, "R9 byte completes at selected speed", status[0], 0);
        end

        // Short: line held low through a reset (R4)
        set_speed(1'b0);
        pres_on = 1'b0;
        short_hold = 1'b1;
        strobe(0);
        wait_idle(bc);
        check(status[2:1] == 2'b10, "R4 short set, presence forced 0", status[2:1], 2);
        // R7 line level on status read, no bus activity
        np = 0;
        strobe(5);
        @(negedge clk);
        check(status[3] == 1'b0, "R7 level low on read", status[3], 0);
        short_hold = 1'b0;
        repeat (4) @(negedge clk);
        check(status[3] == 1'b0, "R7 level holds without read", status[3], 0);
        strobe(5);
        @(negedge clk);
        check(status[3] == 1'b1, "R7 level high after read", status[3], 1);
        check(np == 0 && ow_drive_low == 1'b0, "R7 read drives no bus", np, 0);

        // R4 later clean reset clears both flags
        strobe(0);
        wait_idle(bc);
        check(status[2:1] == 2'b00, "R4 flags cleared by clean reset", status[2:1], 0);

        // R9 overdrive reset timing with presence
        set_speed(1'b1);
        pres_on = 1'b1;
        np = 0;
        strobe(0);
        wait_idle(bc);
        check(np == 1 && pulses[0] == 48*C, "R9 overdrive reset low time", pulses[0], 48*C);
        check(status[2:1] == 2'b01, "R3 overdrive presence", status[2:1], 1);

        // R10 strobes during busy are ignored
        set_speed(1'b0);
        np = 0;
        strobe(0);
        cfg_overdrive = 1'b1;
        strobe(4);
        strobe(3);
        host_data = 8'h00;
        strobe(1);
        strobe(2);
        cfg_overdrive = 1'b0;
        wait_idle(bc);
        check(np == 1, "R10 no extra bus activity", np, 1);
        check(status == 8'h0A, "R10 status untouched by ignored strobes", status, 8'h0A);
        np = 0;
        strobe(0);
        wait_idle(bc);
        check(pulses[0] == 480*C, "R10 speed unchanged by ignored cfg", pulses[0], 480*C);

        // R8 device reset restores after-reset state; R9 speed back to standard
        set_speed(1'b1);
        strobe(5);
        strobe(4);
        @(negedge clk);
        check(status == 8'h10, "R8 device reset status", status, 8'h10);
        od_b = 1'b0;
        np = 0;
        strobe(0);
        wait_idle(bc);
        check(pulses[0] == 480*C, "R9 device reset returns standard speed", pulses[0], 480*C);
        check(status[4] == 1'b1, "R8 bus reset keeps dev-reset flag", status[4], 1);

        finish_run();
    end
endmodule